// File: doc/BRIEF.md
# Flash Sector Write-Protection Guard

This block sits between the asynchronous strobe pins of a parallel flash bus and the flash command engine. It decides, for every bus write, whether the write may reach the engine. It brings the chip-enable, write-enable and output-enable strobes and two supply-related flags into the clock domain. It then drops strobe pulses that are too short to count as a write. A write cycle is completed on the filtered rising edge of write-enable, and the block checks that write against a per-sector protection map before handing it on.

Protection bits are changed through a sideband port that stands for the external programming-equipment path. That port takes effect only while an equipment-mode flag is high. A high-voltage flag on the reset pin lifts all protection for as long as it is present, and the stored bits stay as they were. A low-supply flag, and the power-up sequence that follows reset, both keep the command engine in its read-array state. They also discard any write that is already in progress when the lockout ends.

Top module: `flash_wguard`

## Requirements
- R1: A write cycle exists only while filtered chip-enable and write-enable are both low and filtered output-enable is high. It is accepted on the filtered write-enable rising edge that ends it. An accepted write gives a one-cycle `fwd_vld` with the address and data captured during the cycle.
- R2: Output-enable low for the whole pulse, or chip-enable high, inhibits the write. No `fwd_vld` and no `rej_vld` follow.
- R3: A low pulse on any strobe that lasts fewer than GLITCH_CYC clock periods does not start a write. A pulse of GLITCH_CYC or more periods does.
- R4: A write with `pe_pending` high whose sector (the top SECT_W address bits) has its protect bit set is rejected. The block gives a one-cycle `rej_vld` carrying that sector index and no `fwd_vld`. A write with `pe_pending` low is forwarded whatever the sector's protect bit is.
- R5: Clearing a sector's protect bit lets program/erase writes to that sector be forwarded again.
- R6: After reset every sector is unprotected.
- R7: `prot_wr` changes the bit of sector `prot_sel` to `prot_val` only while `prog_mode` is high. Otherwise the map is unchanged.
- R8: While `hv_reset` is high, protected sectors accept program/erase writes. Once it drops, the same sectors reject them again, and their bits are not altered.
- R9: While `low_vcc` is high, all writes are ignored, with neither `fwd_vld` nor `rej_vld`, and `cmd_hold` is high. Writes are accepted again after `low_vcc` falls.
- R10: A write cycle already active when the lockout ends, either at reset release or when `low_vcc` falls, is not accepted when its write-enable rises. The next full write cycle is accepted.
- R11: During and just after reset, `fwd_vld` and `rej_vld` are low and `cmd_hold` is high. `cmd_hold` stays high until the filtered `low_vcc` is seen low.
- R12: `fwd_vld` and `rej_vld` are never high together, and neither is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset, power-up |
| ce_n | input | 1 | Bus chip-enable, active low, asynchronous |
| we_n | input | 1 | Bus write-enable, active low, asynchronous |
| oe_n | input | 1 | Bus output-enable, active low, asynchronous |
| hv_reset | input | 1 | High-voltage-on-reset-pin flag, asynchronous |
| low_vcc | input | 1 | Supply below lockout threshold flag, asynchronous |
| addr | input | ADDR_W | Bus address, held stable during a write |
| data | input | DATA_W | Bus data, held stable during a write |
| pe_pending | input | 1 | From command engine: this write commits a program or erase |
| prog_mode | input | 1 | Programming-equipment mode flag |
| prot_wr | input | 1 | Sideband protect-bit write strobe |
| prot_sel | input | SECT_W | Sideband sector index |
| prot_val | input | 1 | Sideband protect-bit value |
| fwd_vld | output | 1 | One-cycle strobe: write passed to command engine |
| fwd_addr | output | ADDR_W | Captured address of the forwarded write |
| fwd_data | output | DATA_W | Captured data of the forwarded write |
| rej_vld | output | 1 | One-cycle strobe: write blocked by protection |
| rej_sect | output | SECT_W | Sector index of the blocked write |
| cmd_hold | output | 1 | Holds command engine disabled in read-array state |

## Verification
The bench sends write-enable pulses one period shorter than the filter threshold and pulses exactly at the threshold. A filter that is off by one would either pass the short pulse or drop the exact one. It holds a write cycle open across reset release and runs one while the supply flag is high. A guard without arming logic would forward a command in either case. It raises and drops the high-voltage flag around a protected sector, which catches a design that clears the stored bits or ignores the override. It also drives sideband writes with equipment mode off, which exposes a map that takes writes outside that mode.

// File: rtl/fwg_pkg.sv
`timescale 1ns/1ps
package fwg_pkg;
   // indices of the asynchronous inputs inside the synchroniser vector
   localparam int SIG_CE  = 0;
   localparam int SIG_WE  = 1;
   localparam int SIG_OE  = 2;
   localparam int SIG_HV  = 3;
   localparam int SIG_LV  = 4;
   localparam int NSIG    = 5;
   // reset levels: strobes idle high, no high voltage, supply assumed low
   localparam logic [NSIG-1:0] SIG_RST = 5'b10111;

   typedef enum logic [1:0] {
      VERDICT_NONE = 2'd0,
      VERDICT_FWD  = 2'd1,
      VERDICT_REJ  = 2'd2
   } verdict_e;
endpackage

// File: rtl/fwg_sync.sv
`timescale 1ns/1ps
module fwg_sync #(
   parameter int              W       = 1,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("fwg_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[s] <= RST_VAL;
         end else if (s == 0) begin
            chain[s] <= d_async;
         end else begin
            chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/fwg_filt.sv
`timescale 1ns/1ps
module fwg_filt #(
   parameter int           W       = 1,
   parameter int           MIN_CYC = 3,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] q_flt
);
   if (MIN_CYC < 1) begin : g_bad_min
      $error("fwg_filt: MIN_CYC must be at least 1");
   end

   localparam int CNT_W = (MIN_CYC > 1) ? $clog2(MIN_CYC) : 1;
   localparam logic [CNT_W-1:0] LIM = CNT_W'(MIN_CYC - 1);

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (MIN_CYC == 1) begin : g_pass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_flt[b] <= RST_VAL[b];
            else        q_flt[b] <= d_in[b];
         end
      end else begin : g_count
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_flt[b] <= RST_VAL[b];
               cnt      <= '0;
            end else if (d_in[b] == q_flt[b]) begin
               cnt <= '0;
            end else if (cnt == LIM) begin
               q_flt[b] <= d_in[b];
               cnt      <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/fwg_protmap.sv
`timescale 1ns/1ps
module fwg_protmap #(
   parameter int SECT_W = 4,
   localparam int NSECT = 1 << SECT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_mode,
   input  logic              prot_wr,
   input  logic [SECT_W-1:0] prot_sel,
   input  logic              prot_val,
   input  logic              hv_override,
   output logic [NSECT-1:0]  prot_q,
   output logic [NSECT-1:0]  prot_eff
);
   for (genvar i = 0; i < NSECT; i++) begin : g_sect
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prot_q[i] <= 1'b0;
         end else if (prog_mode && prot_wr && (prot_sel == SECT_W'(i))) begin
            prot_q[i] <= prot_val;
         end
      end
      assign prot_eff[i] = prot_q[i] & ~hv_override;
   end
endmodule

// File: rtl/flash_wguard.sv
`timescale 1ns/1ps
module flash_wguard
   import fwg_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int SECT_W      = 4,
   parameter int GLITCH_CYC  = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic              hv_reset,
   input  logic              low_vcc,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   input  logic              pe_pending,
   input  logic              prog_mode,
   input  logic              prot_wr,
   input  logic [SECT_W-1:0] prot_sel,
   input  logic              prot_val,
   output logic              fwd_vld,
   output logic [ADDR_W-1:0] fwd_addr,
   output logic [DATA_W-1:0] fwd_data,
   output logic              rej_vld,
   output logic [SECT_W-1:0] rej_sect,
   output logic              cmd_hold
);
   localparam int NSECT = 1 << SECT_W;

   if (SECT_W < 1 || SECT_W > ADDR_W) begin : g_bad_sect
      $error("flash_wguard: SECT_W must lie in 1..ADDR_W");
   end
   if (GLITCH_CYC < 1) begin : g_bad_glitch
      $error("flash_wguard: GLITCH_CYC must be at least 1");
   end

   // ---------------- synchronise and filter ----------------
   logic [NSIG-1:0] raw, syn, flt;
   always_comb begin
      raw         = '0;
      raw[SIG_CE] = ce_n;
      raw[SIG_WE] = we_n;
      raw[SIG_OE] = oe_n;
      raw[SIG_HV] = hv_reset;
      raw[SIG_LV] = low_vcc;
   end

   fwg_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(SIG_RST)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(raw), .q_sync(syn));

   fwg_filt #(.W(NSIG), .MIN_CYC(GLITCH_CYC), .RST_VAL(SIG_RST)) u_filt (
      .clk(clk), .rst_n(rst_n), .d_in(syn), .q_flt(flt));

   logic ce_f, we_f, oe_f, hv_f, lv_f;
   assign ce_f = flt[SIG_CE];
   assign we_f = flt[SIG_WE];
   assign oe_f = flt[SIG_OE];
   assign hv_f = flt[SIG_HV];
   assign lv_f = flt[SIG_LV];

   // ---------------- write cycle decode ----------------
   logic              wcyc, wcyc_q, we_q, armed;
   logic              end_evt;
   logic [ADDR_W-1:0] cap_addr;
   logic [DATA_W-1:0] cap_data;

   assign wcyc    = ~ce_f & ~we_f & oe_f;
   assign end_evt = wcyc_q & we_f & ~we_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcyc_q   <= 1'b0;
         we_q     <= 1'b1;
         armed    <= 1'b0;
         cap_addr <= '0;
         cap_data <= '0;
      end else begin
         wcyc_q <= wcyc;
         we_q   <= we_f;
         if (lv_f)       armed <= 1'b0;
         else if (!wcyc) armed <= 1'b1;
         if (wcyc) begin
            cap_addr <= addr;
            cap_data <= data;
         end
      end
   end

   // ---------------- protection ----------------
   logic [NSECT-1:0]  prot_q, prot_eff;
   logic [SECT_W-1:0] cur_sect;

   fwg_protmap #(.SECT_W(SECT_W)) u_map (
      .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .prot_wr(prot_wr),
      .prot_sel(prot_sel), .prot_val(prot_val), .hv_override(hv_f),
      .prot_q(prot_q), .prot_eff(prot_eff));

   assign cur_sect = cap_addr[ADDR_W-1 -: SECT_W];

   verdict_e verdict;
   always_comb begin
      verdict = VERDICT_NONE;
      if (end_evt && armed && !lv_f) begin
         if (pe_pending && prot_eff[cur_sect]) verdict = VERDICT_REJ;
         else                                  verdict = VERDICT_FWD;
      end
   end

   // ---------------- registered outputs ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fwd_vld  <= 1'b0;
         fwd_addr <= '0;
         fwd_data <= '0;
         rej_vld  <= 1'b0;
         rej_sect <= '0;
         cmd_hold <= 1'b1;
      end else begin
         fwd_vld  <= (verdict == VERDICT_FWD);
         rej_vld  <= (verdict == VERDICT_REJ);
         cmd_hold <= lv_f;
         if (verdict == VERDICT_FWD) begin
            fwd_addr <= cap_addr;
            fwd_data <= cap_data;
         end
         if (verdict == VERDICT_REJ) rej_sect <= cur_sect;
      end
   end
endmodule

// File: rtl/fwg_chk.sv
`timescale 1ns/1ps
module fwg_chk #(
   parameter int SECT_W = 4,
   localparam int NSECT = 1 << SECT_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lv_f,
   input logic             hv_f,
   input logic             prog_mode,
   input logic [NSECT-1:0] prot_q,
   input logic             fwd_vld,
   input logic             rej_vld,
   input logic             cmd_hold
);
   AST_FWD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_vld |=> !fwd_vld); // R12
   AST_REJ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rej_vld |=> !rej_vld); // R12
   AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(fwd_vld && rej_vld)); // R12
   AST_LOCKOUT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      lv_f |=> !(fwd_vld || rej_vld)); // R9
   AST_LOCKOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      lv_f |=> cmd_hold); // R9
   AST_HV_NO_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      hv_f |=> !rej_vld); // R8
   AST_MAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_mode |=> $stable(prot_q)); // R7
endmodule

bind flash_wguard fwg_chk #(.SECT_W(SECT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lv_f(lv_f), .hv_f(hv_f), .prog_mode(prog_mode),
   .prot_q(prot_q), .fwd_vld(fwd_vld), .rej_vld(rej_vld), .cmd_hold(cmd_hold));

// File: tb/flash_wguard_tb.sv
`timescale 1ns/1ps
module flash_wguard_tb_top;
   localparam int ADDR_W = 16;
   localparam int DATA_W = 8;
   localparam int SECT_W = 4;
   localparam int G      = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, hv_reset = 1'b0, low_vcc = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] data = '0;
   logic pe_pending = 1'b0, prog_mode = 1'b0, prot_wr = 1'b0, prot_val = 1'b0;
   logic [SECT_W-1:0] prot_sel = '0;
   logic fwd_vld, rej_vld, cmd_hold;
   logic [ADDR_W-1:0] fwd_addr;
   logic [DATA_W-1:0] fwd_data;
   logic [SECT_W-1:0] rej_sect;

   always #5 clk = ~clk;

   flash_wguard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W),
                  .GLITCH_CYC(G), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .hv_reset(hv_reset), .low_vcc(low_vcc), .addr(addr), .data(data),
      .pe_pending(pe_pending), .prog_mode(prog_mode), .prot_wr(prot_wr),
      .prot_sel(prot_sel), .prot_val(prot_val), .fwd_vld(fwd_vld),
      .fwd_addr(fwd_addr), .fwd_data(fwd_data), .rej_vld(rej_vld),
      .rej_sect(rej_sect), .cmd_hold(cmd_hold));

   int total = 0, bad = 0;
   int n_fwd = 0, n_rej = 0;
   logic [ADDR_W-1:0] l_addr;
   logic [DATA_W-1:0] l_data;
   logic [SECT_W-1:0] l_sect;
   logic prot_m [1<<SECT_W];
   logic hv_m = 1'b0;
   bit   done = 1'b0;

   always @(negedge clk) begin
      if (fwd_vld) begin n_fwd++; l_addr = fwd_addr; l_data = fwd_data; end
      if (rej_vld) begin n_rej++; l_sect = rej_sect; end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [SECT_W-1:0] sect_of(input logic [ADDR_W-1:0] a);
      return a[ADDR_W-1 -: SECT_W];
   endfunction

   function automatic bit expect_rej(input logic [ADDR_W-1:0] a, input logic pe);
      return pe && prot_m[sect_of(a)] && !hv_m;
   endfunction

   // generic strobe pulse: we_n low for w periods inside a ce_n low window
   task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                            input logic pe, input int w, input logic oe_lvl, input logic ce_lvl);
      @(negedge clk);
      addr = a; data = d; pe_pending = pe; oe_n = oe_lvl; ce_n = ce_lvl;
      cyc(1); we_n = 1'b0;
      cyc(w); we_n = 1'b1;
      cyc(1); ce_n = 1'b1; oe_n = 1'b1;
      cyc(10);
   endtask

   task automatic sideband(input logic pm, input logic [SECT_W-1:0] s, input logic v);
      @(negedge clk);
      prog_mode = pm; prot_wr = 1'b1; prot_sel = s; prot_val = v;
      @(negedge clk);
      prot_wr = 1'b0; prog_mode = 1'b0;
      if (pm) prot_m[s] = v;
   endtask

   task automatic set_hv(input logic v);
      @(negedge clk); hv_reset = v; hv_m = v; cyc(10);
   endtask

   // checked write with the bench model deciding the verdict
   task automatic mwrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                         input logic pe, input string req);
      int f0, r0;
      bit rj;
      f0 = n_fwd; r0 = n_rej;
      rj = expect_rej(a, pe);
      bus_write(a, d, pe, G + 2, 1'b1, 1'b0);
      if (rj) begin
         chk(n_rej == r0 + 1 && n_fwd == f0, req, n_rej - r0, 1);
         chk(l_sect == sect_of(a), req, l_sect, sect_of(a));
      end else begin
         chk(n_fwd == f0 + 1 && n_rej == r0, req, n_fwd - f0, 1);
         chk(l_addr == a && l_data == d, req, {l_addr, l_data}, {a, d});
      end
   endtask

   task automatic expect_none(input int f0, input int r0, input string req);
      chk(n_fwd == f0 && n_rej == r0, req, (n_fwd - f0) + (n_rej - r0), 0);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int f0, r0;
      void'($urandom(32'h1F2E3D4C));
      for (int i = 0; i < (1 << SECT_W); i++) prot_m[i] = 1'b0;
      cyc(4);
      // R11: reset state
      chk(fwd_vld == 0 && rej_vld == 0, "R11", {fwd_vld, rej_vld}, 0);
      chk(cmd_hold == 1, "R11", cmd_hold, 1);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_hold == 1, "R11", cmd_hold, 1);
      cyc(10);
      chk(cmd_hold == 0, "R11", cmd_hold, 0);

      // R6: all sectors unprotected after reset
      for (int s = 0; s < (1 << SECT_W); s++)
         mwrite({SECT_W'(s), 12'h0A5}, 8'(s + 8'h30), 1'b1, "R6");

      // R1: plain writes with distinct patterns
      mwrite(16'h1234, 8'hA5, 1'b0, "R1");
      mwrite(16'hFFFF, 8'h00, 1'b1, "R1");
      mwrite(16'h0000, 8'hFF, 1'b0, "R1");

      // R2: output-enable low inhibits; chip-enable high inhibits
      f0 = n_fwd; r0 = n_rej;
      bus_write(16'h2222, 8'h11, 1'b0, G + 2, 1'b0, 1'b0);
      expect_none(f0, r0, "R2");
      bus_write(16'h3333, 8'h22, 1'b0, G + 2, 1'b1, 1'b1);
      expect_none(f0, r0, "R2");

      // R3: glitch threshold
      f0 = n_fwd; r0 = n_rej;
      bus_write(16'h4444, 8'h33, 1'b0, G - 1, 1'b1, 1'b0);
      expect_none(f0, r0, "R3");
      @(negedge clk); we_n = 1'b0; cyc(1); ce_n = 1'b0; cyc(G - 1); ce_n = 1'b1;
      cyc(1); we_n = 1'b1; cyc(10);
      expect_none(f0, r0, "R3");
      f0 = n_fwd;
      bus_write(16'h4545, 8'h34, 1'b0, G, 1'b1, 1'b0);
      chk(n_fwd == f0 + 1 && l_data == 8'h34, "R3", n_fwd - f0, 1);

      // R4: protect a sector
      sideband(1'b1, 4'd5, 1'b1);
      mwrite(16'h5001, 8'h44, 1'b1, "R4");
      mwrite(16'h5002, 8'h45, 1'b0, "R4");
      mwrite(16'h6003, 8'h46, 1'b1, "R4");

      // R8: high-voltage override and return
      set_hv(1'b1);
      mwrite(16'h5004, 8'h47, 1'b1, "R8");
      set_hv(1'b0);
      mwrite(16'h5005, 8'h48, 1'b1, "R8");

      // R7: sideband ignored without equipment mode
      sideband(1'b0, 4'd3, 1'b1);
      mwrite(16'h3006, 8'h49, 1'b1, "R7");
      sideband(1'b0, 4'd5, 1'b0);
      mwrite(16'h5007, 8'h4A, 1'b1, "R7");

      // R5: clearing re-enables
      sideband(1'b1, 4'd5, 1'b0);
      mwrite(16'h5008, 8'h4B, 1'b1, "R5");

      // R9: supply lockout
      sideband(1'b1, 4'd9, 1'b1);
      @(negedge clk); low_vcc = 1'b1; cyc(10);
      chk(cmd_hold == 1, "R9", cmd_hold, 1);
      f0 = n_fwd; r0 = n_rej;
      bus_write(16'h1111, 8'h55, 1'b0, G + 2, 1'b1, 1'b0);
      bus_write(16'h9111, 8'h56, 1'b1, G + 2, 1'b1, 1'b0);
      expect_none(f0, r0, "R9");
      @(negedge clk); low_vcc = 1'b0; cyc(10);
      chk(cmd_hold == 0, "R9", cmd_hold, 0);
      mwrite(16'h1112, 8'h57, 1'b0, "R9");

      // R10: write already open when lockout ends (supply)
      @(negedge clk); low_vcc = 1'b1; cyc(10);
      addr = 16'h7777; data = 8'h66; pe_pending = 1'b0;
      ce_n = 1'b0; cyc(1); we_n = 1'b0; cyc(2);
      low_vcc = 1'b0; cyc(12);
      f0 = n_fwd; r0 = n_rej;
      we_n = 1'b1; cyc(1); ce_n = 1'b1; cyc(10);
      expect_none(f0, r0, "R10");
      mwrite(16'h7778, 8'h67, 1'b0, "R10");

      // R10: write open across reset release
      @(negedge clk); rst_n = 1'b0;
      for (int i = 0; i < (1 << SECT_W); i++) prot_m[i] = 1'b0;
      addr = 16'h8888; data = 8'h77; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
      cyc(3); rst_n = 1'b1; cyc(12);
      f0 = n_fwd; r0 = n_rej;
      we_n = 1'b1; cyc(1); ce_n = 1'b1; cyc(10);
      expect_none(f0, r0, "R10");
      mwrite(16'h9889, 8'h78, 1'b1, "R6");

      // constrained random mix, R4 R5 R7 R8
      for (int it = 0; it < 150; it++) begin
         int k;
         k = $urandom_range(0, 9);
         if (k < 3) sideband(1'($urandom_range(0, 3) != 0), SECT_W'($urandom), 1'($urandom));
         else if (k == 3) set_hv(~hv_m);
         mwrite(ADDR_W'($urandom), DATA_W'($urandom), 1'($urandom_range(0, 3) != 0), "R4");
      end
      if (hv_m) set_hv(1'b0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule